// File: doc/BRIEF.md
# Extrinsic LLR Writeback Unit

This block sits behind the node units of a layered LDPC decoder and runs during the final decoding iteration. Each cycle it can take one vector of a posteriori LLRs, one per lane, together with the block-column index that the vector belongs to. The decoder rotated these lanes by a known amount at its input, so the block first reverses that rotation. It then reads the matching a priori word from a shared LLR memory. The extrinsic LLR is the posterior minus the prior, clipped to the LLR range, and the block writes it back over the prior. The shared memory is a synchronous RAM outside the block, with one read port and one write port.

Two extra single-bit results are produced for each code bit, for a later detection pass that runs only where it is needed. The first is a reliability flag: it is set when the posterior magnitude, clipped to five bits, reaches a threshold that can be set per vector. The second is the sign of the old prior, kept before the write replaces that prior. Each kind of bit has its own internal memory, organised as one word of lane bits per block column. The detector reads both memories through a registered read port.

The active lane count Z is chosen per vector at run time as one, two or three thirds of the lane capacity. The rotation is taken modulo Z. Lanes at or above Z carry zeros. The pipeline has four stages and accepts one vector per cycle. A stall input freezes every stage.

Top module: `llr_extr_writeback`

## Requirements
- R1: After reset, no read or write request is driven to the shared memory, and every flag bit and old-sign bit reads as 0 through the detector port.
- R2: Output lane k (k < Z) is derived from the input lane at index (k - s) mod Z, where s is the rotation amount given with the vector (s < Z).
- R3: One cycle after a vector is accepted, and while not stalled, the block drives a shared-memory read of the vector's column.
- R4: Three cycles after acceptance, if no stall occurred in between, the block drives a shared-memory write to the same column carrying the extrinsic word.
- R5: Each extrinsic lane equals posterior minus prior, both in two's complement, saturated to the range [-(2^(W-1)-1), 2^(W-1)-1]. For W = 8 the value 8'h80 is never written.
- R6: The flag bit for lane k of the column is 1 exactly when min(|posterior|, 31) >= threshold. The threshold is 5 bits wide, and flags are stored in unrotated lane order.
- R7: The old-sign bit for lane k of the column is the most significant bit of the prior that was read for that lane.
- R8: Lane-count code 0 selects Z = ZMAX/3, code 1 selects 2*ZMAX/3, and codes 2 and 3 select ZMAX. Lanes k >= Z get extrinsic value 0, flag 0 and sign bit 0.
- R9: Vectors presented on consecutive cycles are all accepted. Their writes then come out on consecutive cycles in the order the vectors arrived.
- R10: While stall is high, no vector is accepted, no read or write request is driven, and no stage advances. Results after the stall match those of an unstalled run.
- R11: The detector read port returns the flag and old-sign words of the addressed column one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freezes all pipeline stages |
| in_vld_i | input | 1 | Posterior vector valid |
| in_col_i | input | $clog2(NCOL) | Block-column index of the vector |
| in_shift_i | input | $clog2(ZMAX+1) | Rotation applied at the decoder input |
| in_zsel_i | input | 2 | Lane-count code |
| in_thr_i | input | MAGW | Reliability threshold |
| in_post_i | input | ZMAX*LLRW | Rotated posterior LLRs, lane 0 in the low bits |
| mem_rd_en_o | output | 1 | Shared-memory read request |
| mem_rd_addr_o | output | $clog2(NCOL) | Shared-memory read address |
| mem_rd_data_i | input | ZMAX*LLRW | Prior word, one cycle after the request |
| mem_wr_en_o | output | 1 | Shared-memory write request |
| mem_wr_addr_o | output | $clog2(NCOL) | Shared-memory write address |
| mem_wr_data_o | output | ZMAX*LLRW | Extrinsic word |
| det_addr_i | input | $clog2(NCOL) | Detector-side column address |
| det_flag_o | output | ZMAX | Stored reliability flags of that column |
| det_sign_o | output | ZMAX | Stored old-sign bits of that column |

## Verification
The hardest case to reach is a stall that arrives while several vectors are in flight. In that case a frozen middle stage must still find its prior on the read-data bus, because the RAM output register only holds while no new read is issued. The bench creates this by sending two vectors one cycle apart and then raising stall twice: once while the first vector waits for its prior, and again while it waits to write. It checks that no memory request appears during either stall and that both columns end up with the same words as an unstalled run. A vector that is valid only while stalled must leave its column and bit memories untouched.

// File: rtl/llr_wb_pkg.sv
package llr_wb_pkg;

    typedef enum logic [1:0] {
        ZSEL_THIRD      = 2'd0,
        ZSEL_TWO_THIRDS = 2'd1,
        ZSEL_FULL       = 2'd2,
        ZSEL_FULL_ALT   = 2'd3
    } zsel_e;

    // Active lane count for a lane-count code and a lane capacity.
    function automatic int unsigned lanes_for(input logic [1:0] sel, input int unsigned zmax);
        case (zsel_e'(sel))
            ZSEL_THIRD:      return zmax / 3;
            ZSEL_TWO_THIRDS: return 2 * (zmax / 3);
            default:         return zmax;
        endcase
    endfunction

endpackage

// File: rtl/wbu_unrotate.sv
module wbu_unrotate #(
    parameter int ZMAX = 81,
    parameter int LLRW = 8
) (
    input  logic [$clog2(ZMAX+1)-1:0] z,
    input  logic [$clog2(ZMAX+1)-1:0] shift,
    input  logic [ZMAX*LLRW-1:0]      din,
    output logic [ZMAX*LLRW-1:0]      dout
);

    localparam int ZW = $clog2(ZMAX + 1);
    localparam int IW = $clog2(ZMAX);

    logic [LLRW-1:0] lane_in [ZMAX];

    for (genvar j = 0; j < ZMAX; j++) begin : g_split
        assign lane_in[j] = din[j*LLRW +: LLRW];
    end

    // Output lane k takes source lane (k - shift) mod z.
    for (genvar k = 0; k < ZMAX; k++) begin : g_lane
        localparam logic [ZW:0] KPOS = (ZW+1)'(k);
        logic [ZW:0]     src;
        logic [LLRW-1:0] pick;

        always_comb begin
            src  = '0;
            pick = '0;
            if (KPOS < {1'b0, z}) begin
                if (KPOS >= {1'b0, shift}) begin
                    src = KPOS - {1'b0, shift};
                end else begin
                    src = KPOS + {1'b0, z} - {1'b0, shift};
                end
                if (src < (ZW+1)'(ZMAX)) begin
                    pick = lane_in[IW'(src)];
                end
            end
        end

        assign dout[k*LLRW +: LLRW] = pick;
    end

endmodule

// File: rtl/wbu_lane.sv
module wbu_lane #(
    parameter int LLRW = 8,
    parameter int MAGW = 5
) (
    input  logic            act,
    input  logic [LLRW-1:0] post,
    input  logic [LLRW-1:0] prior,
    input  logic [MAGW-1:0] thr,
    output logic [LLRW-1:0] ext,
    output logic            flag,
    output logic            sgn
);

    localparam logic signed [LLRW:0] SAT_HI = (LLRW+1)'(2**(LLRW-1) - 1);
    localparam logic signed [LLRW:0] SAT_LO = -SAT_HI;
    localparam logic [LLRW-1:0]      MAG_CAP = LLRW'(2**MAGW - 1);

    logic signed [LLRW:0] diff;
    logic [LLRW-1:0]      mag;
    logic [MAGW-1:0]      mag_c;

    always_comb begin
        diff = $signed({post[LLRW-1], post}) - $signed({prior[LLRW-1], prior});
        ext  = '0;
        if (act) begin
            if (diff > SAT_HI) begin
                ext = SAT_HI[LLRW-1:0];
            end else if (diff < SAT_LO) begin
                ext = SAT_LO[LLRW-1:0];
            end else begin
                ext = diff[LLRW-1:0];
            end
        end

        mag = post[LLRW-1] ? (~post + LLRW'(1)) : post;
        if (mag > MAG_CAP) begin
            mag_c = MAG_CAP[MAGW-1:0];
        end else begin
            mag_c = mag[MAGW-1:0];
        end
        flag = act && (mag_c >= thr);
        sgn  = act && prior[LLRW-1];
    end

endmodule

// File: rtl/wbu_bitmem.sv
module wbu_bitmem #(
    parameter int NCOL = 24,
    parameter int ZMAX = 81
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NCOL)-1:0] waddr,
    input  logic [ZMAX-1:0]         wdata,
    input  logic [$clog2(NCOL)-1:0] raddr,
    output logic [ZMAX-1:0]         rdata
);

    typedef struct packed {
        logic [NCOL-1:0][ZMAX-1:0] mem;
        logic [ZMAX-1:0]           rd;
    } bm_state_t;

    bm_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.rd = st_q.mem[raddr];
        if (we) begin
            st_d.mem[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rd;

endmodule

// File: rtl/llr_extr_writeback.sv
module llr_extr_writeback #(
    parameter int ZMAX = 81,
    parameter int LLRW = 8,
    parameter int NCOL = 24,
    parameter int MAGW = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stall_i,
    input  logic                      in_vld_i,
    input  logic [$clog2(NCOL)-1:0]   in_col_i,
    input  logic [$clog2(ZMAX+1)-1:0] in_shift_i,
    input  logic [1:0]                in_zsel_i,
    input  logic [MAGW-1:0]           in_thr_i,
    input  logic [ZMAX*LLRW-1:0]      in_post_i,
    output logic                      mem_rd_en_o,
    output logic [$clog2(NCOL)-1:0]   mem_rd_addr_o,
    input  logic [ZMAX*LLRW-1:0]      mem_rd_data_i,
    output logic                      mem_wr_en_o,
    output logic [$clog2(NCOL)-1:0]   mem_wr_addr_o,
    output logic [ZMAX*LLRW-1:0]      mem_wr_data_o,
    input  logic [$clog2(NCOL)-1:0]   det_addr_i,
    output logic [ZMAX-1:0]           det_flag_o,
    output logic [ZMAX-1:0]           det_sign_o
);

    import llr_wb_pkg::*;

    localparam int CW = $clog2(NCOL);
    localparam int ZW = $clog2(ZMAX + 1);
    localparam int VW = ZMAX * LLRW;

    typedef struct packed {
        // stage 1: unrotated posterior, read issued
        logic            s1_v;
        logic [CW-1:0]   s1_col;
        logic [ZW-1:0]   s1_z;
        logic [MAGW-1:0] s1_thr;
        logic [VW-1:0]   s1_post;
        // stage 2: prior arrives on the read bus
        logic            s2_v;
        logic [CW-1:0]   s2_col;
        logic [ZW-1:0]   s2_z;
        logic [MAGW-1:0] s2_thr;
        logic [VW-1:0]   s2_post;
        // stage 3: results ready for the write
        logic            s3_v;
        logic [CW-1:0]   s3_col;
        logic [VW-1:0]   s3_ext;
        logic [ZMAX-1:0] s3_flag;
        logic [ZMAX-1:0] s3_sign;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [ZW-1:0]   in_z;
    logic [VW-1:0]   unrot;
    logic [VW-1:0]   ext_vec;
    logic [ZMAX-1:0] flag_vec;
    logic [ZMAX-1:0] sign_vec;
    logic            advance;

    assign in_z    = ZW'(lanes_for(in_zsel_i, ZMAX));
    assign advance = !stall_i;

    wbu_unrotate #(
        .ZMAX (ZMAX),
        .LLRW (LLRW)
    ) u_unrot (
        .z     (in_z),
        .shift (in_shift_i),
        .din   (in_post_i),
        .dout  (unrot)
    );

    for (genvar k = 0; k < ZMAX; k++) begin : g_lane
        localparam logic [ZW:0] KPOS = (ZW+1)'(k);
        logic act;
        assign act = KPOS < {1'b0, pipe_q.s2_z};

        wbu_lane #(
            .LLRW (LLRW),
            .MAGW (MAGW)
        ) u_lane (
            .act   (act),
            .post  (pipe_q.s2_post[k*LLRW +: LLRW]),
            .prior (mem_rd_data_i[k*LLRW +: LLRW]),
            .thr   (pipe_q.s2_thr),
            .ext   (ext_vec[k*LLRW +: LLRW]),
            .flag  (flag_vec[k]),
            .sgn   (sign_vec[k])
        );
    end

    always_comb begin
        pipe_d = pipe_q;
        if (advance) begin
            pipe_d.s1_v    = in_vld_i;
            pipe_d.s1_col  = in_col_i;
            pipe_d.s1_z    = in_z;
            pipe_d.s1_thr  = in_thr_i;
            pipe_d.s1_post = unrot;

            pipe_d.s2_v    = pipe_q.s1_v;
            pipe_d.s2_col  = pipe_q.s1_col;
            pipe_d.s2_z    = pipe_q.s1_z;
            pipe_d.s2_thr  = pipe_q.s1_thr;
            pipe_d.s2_post = pipe_q.s1_post;

            pipe_d.s3_v    = pipe_q.s2_v;
            pipe_d.s3_col  = pipe_q.s2_col;
            pipe_d.s3_ext  = ext_vec;
            pipe_d.s3_flag = flag_vec;
            pipe_d.s3_sign = sign_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign mem_rd_en_o   = pipe_q.s1_v && advance;
    assign mem_rd_addr_o = pipe_q.s1_col;
    assign mem_wr_en_o   = pipe_q.s3_v && advance;
    assign mem_wr_addr_o = pipe_q.s3_col;
    assign mem_wr_data_o = pipe_q.s3_ext;

    wbu_bitmem #(
        .NCOL (NCOL),
        .ZMAX (ZMAX)
    ) u_flag_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_wr_en_o),
        .waddr (pipe_q.s3_col),
        .wdata (pipe_q.s3_flag),
        .raddr (det_addr_i),
        .rdata (det_flag_o)
    );

    wbu_bitmem #(
        .NCOL (NCOL),
        .ZMAX (ZMAX)
    ) u_sign_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_wr_en_o),
        .waddr (pipe_q.s3_col),
        .wdata (pipe_q.s3_sign),
        .raddr (det_addr_i),
        .rdata (det_sign_o)
    );

endmodule

// File: rtl/wbu_checker.sv
module wbu_checker #(
    parameter int ZMAX = 81,
    parameter int LLRW = 8,
    parameter int NCOL = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    stall_i,
    input logic                    in_vld_i,
    input logic [$clog2(NCOL)-1:0] in_col_i,
    input logic [1:0]              in_zsel_i,
    input logic                    mem_rd_en_o,
    input logic [$clog2(NCOL)-1:0] mem_rd_addr_o,
    input logic                    mem_wr_en_o,
    input logic [$clog2(NCOL)-1:0] mem_wr_addr_o,
    input logic [ZMAX*LLRW-1:0]    mem_wr_data_o
);

    localparam int VW    = ZMAX * LLRW;
    localparam int THIRD = ZMAX / 3;

    function automatic logic lane_at_min(input logic [VW-1:0] w);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < ZMAX; k++) begin
            if (w[k*LLRW +: LLRW] == {1'b1, {(LLRW-1){1'b0}}}) hit = 1'b1;
        end
        return hit;
    endfunction

    // R3
    rd_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_vld_i && !stall_i) && !stall_i)
        |-> (mem_rd_en_o && mem_rd_addr_o == $past(in_col_i)));

    // R4
    wr_after_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1)
         && $past(in_vld_i && !stall_i, 3) && !$past(stall_i, 2) && !$past(stall_i, 1) && !stall_i)
        |-> (mem_wr_en_o && mem_wr_addr_o == $past(in_col_i, 3)));

    // R10
    stall_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> (!mem_rd_en_o && !mem_wr_en_o));

    // R8
    narrow_lanes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1)
         && $past(in_vld_i && !stall_i, 3) && $past(in_zsel_i, 3) == 2'd0
         && !$past(stall_i, 2) && !$past(stall_i, 1) && !stall_i)
        |-> (mem_wr_data_o[VW-1:THIRD*LLRW] == '0));

    // R5
    sat_no_minval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en_o |-> !lane_at_min(mem_wr_data_o));

endmodule

bind llr_extr_writeback wbu_checker #(
    .ZMAX (ZMAX),
    .LLRW (LLRW),
    .NCOL (NCOL)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_i       (stall_i),
    .in_vld_i      (in_vld_i),
    .in_col_i      (in_col_i),
    .in_zsel_i     (in_zsel_i),
    .mem_rd_en_o   (mem_rd_en_o),
    .mem_rd_addr_o (mem_rd_addr_o),
    .mem_wr_en_o   (mem_wr_en_o),
    .mem_wr_addr_o (mem_wr_addr_o),
    .mem_wr_data_o (mem_wr_data_o)
);

// File: tb/llr_extr_writeback_tb.sv
module llr_extr_writeback_tb;

    localparam int ZMAX = 81;
    localparam int W    = 8;
    localparam int NCOL = 24;
    localparam int MAGW = 5;
    localparam int CW   = $clog2(NCOL);
    localparam int ZW   = $clog2(ZMAX + 1);
    localparam int VW   = ZMAX * W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            stall = 1'b0;
    logic            in_vld = 1'b0;
    logic [CW-1:0]   in_col = '0;
    logic [ZW-1:0]   in_shift = '0;
    logic [1:0]      in_zsel = '0;
    logic [MAGW-1:0] in_thr = '0;
    logic [VW-1:0]   in_post = '0;
    logic            rd_en, wr_en;
    logic [CW-1:0]   rd_addr, wr_addr;
    logic [VW-1:0]   rd_data = '0;
    logic [VW-1:0]   wr_data;
    logic [CW-1:0]   det_addr = '0;
    logic [ZMAX-1:0] det_flag, det_sign;

    logic            pre_we = 1'b0;
    logic [CW-1:0]   pre_addr = '0;
    logic [VW-1:0]   pre_data = '0;

    logic [VW-1:0]   bram    [NCOL];
    logic [VW-1:0]   prior_w [NCOL];
    logic [VW-1:0]   exp_w   [NCOL];
    logic [ZMAX-1:0] exp_f   [NCOL];
    logic [ZMAX-1:0] exp_s   [NCOL];

    int checks = 0;
    int fails  = 0;
    int unsigned seed = 32'h2468ace1;

    llr_extr_writeback #(
        .ZMAX (ZMAX), .LLRW (W), .NCOL (NCOL), .MAGW (MAGW)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .stall_i       (stall),
        .in_vld_i      (in_vld),
        .in_col_i      (in_col),
        .in_shift_i    (in_shift),
        .in_zsel_i     (in_zsel),
        .in_thr_i      (in_thr),
        .in_post_i     (in_post),
        .mem_rd_en_o   (rd_en),
        .mem_rd_addr_o (rd_addr),
        .mem_rd_data_i (rd_data),
        .mem_wr_en_o   (wr_en),
        .mem_wr_addr_o (wr_addr),
        .mem_wr_data_o (wr_data),
        .det_addr_i    (det_addr),
        .det_flag_o    (det_flag),
        .det_sign_o    (det_sign)
    );

    // Shared LLR RAM model: synchronous read, bench preload port.
    always @(posedge clk) begin
        if (wr_en) bram[wr_addr] <= wr_data;
        else if (pre_we) bram[pre_addr] <= pre_data;
        if (rd_en) rd_data <= bram[rd_addr];
    end

    task automatic chk(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic logic [W-1:0] rnd8();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[23:16];
    endfunction

    function automatic logic [VW-1:0] rand_word();
        logic [VW-1:0] w;
        for (int k = 0; k < ZMAX; k++) w[k*W +: W] = rnd8();
        return w;
    endfunction

    function automatic int zof(input logic [1:0] s);
        return (s == 2'd3) ? ZMAX : (ZMAX / 3) * (int'(s) + 1);
    endfunction

    function automatic logic [VW-1:0] make_dec(input logic [VW-1:0] nat, input int s, input int z);
        logic [VW-1:0] d;
        for (int j = 0; j < ZMAX; j++) begin
            if (j < z) d[j*W +: W] = nat[((j + s) % z)*W +: W];
            else       d[j*W +: W] = 8'hA5;
        end
        return d;
    endfunction

    task automatic set_expect(input int col, input logic [VW-1:0] nat, input int z, input int thr);
        for (int k = 0; k < ZMAX; k++) begin
            logic signed [W-1:0] p, q;
            int d, m;
            p = nat[k*W +: W];
            q = prior_w[col][k*W +: W];
            if (k < z) begin
                d = int'(p) - int'(q);
                if (d > 127) d = 127;
                if (d < -127) d = -127;
                exp_w[col][k*W +: W] = W'(d);
                m = (p < 0) ? -int'(p) : int'(p);
                if (m > 31) m = 31;
                exp_f[col][k] = (m >= thr);
                exp_s[col][k] = q[W-1];
            end else begin
                exp_w[col][k*W +: W] = '0;
                exp_f[col][k] = 1'b0;
                exp_s[col][k] = 1'b0;
            end
        end
    endtask

    task automatic preload(input int col, input logic [VW-1:0] word);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = CW'(col); pre_data = word;
        @(negedge clk);
        pre_we = 1'b0;
        prior_w[col] = word;
    endtask

    // Call just after a falling edge; the vector is taken at the next rising edge.
    task automatic drive(input int col, input int s, input logic [1:0] zs, input int thr, input logic [VW-1:0] nat);
        in_vld = 1'b1; in_col = CW'(col); in_shift = ZW'(s); in_zsel = zs; in_thr = MAGW'(thr);
        in_post = make_dec(nat, s, zof(zs));
        set_expect(col, nat, zof(zs), thr);
    endtask

    task automatic check_col(input int col, input string req);
        chk(bram[col] === exp_w[col], req,
            $sformatf("col %0d word act=%h exp=%h", col, bram[col], exp_w[col]));
        det_addr = CW'(col);
        @(negedge clk);
        chk(det_flag === exp_f[col], "R6", $sformatf("col %0d flags act=%h exp=%h", col, det_flag, exp_f[col]));
        chk(det_sign === exp_s[col], "R7", $sformatf("col %0d signs act=%h exp=%h", col, det_sign, exp_s[col]));
    endtask

    task automatic run_one(input int col, input int s, input logic [1:0] zs, input int thr,
                           input logic [VW-1:0] nat, input string req);
        @(negedge clk);
        drive(col, s, zs, thr, nat);
        @(negedge clk);
        in_vld = 1'b0;
        repeat (5) @(negedge clk);
        check_col(col, req);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!rd_en && !wr_en, "R1", $sformatf("in reset rd=%b wr=%b exp=0/0", rd_en, wr_en));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_en && !wr_en, "R1", $sformatf("after reset rd=%b wr=%b exp=0/0", rd_en, wr_en));
        det_addr = '0;
        @(negedge clk);
        chk(det_flag == '0 && det_sign == '0, "R1",
            $sformatf("bit memories act=%h/%h exp=0", det_flag, det_sign));
    endtask

    task automatic t_latency();
        logic [VW-1:0] nat;
        nat = rand_word();
        preload(1, rand_word());
        @(negedge clk);
        drive(1, 5, 2'd2, 10, nat);
        @(negedge clk);
        in_vld = 1'b0;
        chk(rd_en && rd_addr == CW'(1), "R3", $sformatf("rd act=%b/%0d exp=1/1", rd_en, rd_addr));
        @(negedge clk);
        chk(!wr_en, "R4", $sformatf("early write act=%b exp=0", wr_en));
        @(negedge clk);
        chk(wr_en && wr_addr == CW'(1), "R4", $sformatf("wr act=%b/%0d exp=1/1", wr_en, wr_addr));
        repeat (3) @(negedge clk);
        check_col(1, "R2");
    endtask

    task automatic t_shift();
        preload(3, rand_word()); preload(4, rand_word());
        preload(5, rand_word()); preload(6, rand_word());
        run_one(3, 26, 2'd0, 12, rand_word(), "R8");
        run_one(4, 53, 2'd1, 12, rand_word(), "R8");
        run_one(5, 80, 2'd2, 12, rand_word(), "R2");
        run_one(6, 40, 2'd3, 12, rand_word(), "R8");
    endtask

    task automatic t_sat();
        logic [VW-1:0] pr, nat;
        for (int k = 0; k < ZMAX; k++) begin
            pr[k*W +: W]  = (k % 2 == 0) ? 8'h80 : 8'h7F;
            nat[k*W +: W] = (k % 2 == 0) ? 8'h7F : 8'h80;
        end
        preload(7, pr);
        run_one(7, 17, 2'd2, 31, nat, "R5");
        chk(bram[7][7:0] == 8'h7F && bram[7][15:8] == 8'h81, "R5",
            $sformatf("lanes0/1 act=%h/%h exp=7f/81", bram[7][7:0], bram[7][15:8]));
    endtask

    task automatic t_thresh();
        preload(8, rand_word()); preload(9, rand_word()); preload(13, rand_word());
        run_one(8, 9, 2'd1, 0, rand_word(), "R6");
        run_one(9, 3, 2'd2, 31, rand_word(), "R6");
        run_one(13, 70, 2'd3, 17, rand_word(), "R6");
    endtask

    task automatic t_b2b();
        int cnt, first, last;
        cnt = 0; first = -1; last = -1;
        for (int i = 0; i < 6; i++) preload(14 + i, rand_word());
        @(negedge clk);
        for (int c = 0; c < 12; c++) begin
            if (wr_en) begin
                cnt++;
                if (first < 0) first = c;
                last = c;
            end
            if (c < 6) begin
                logic [1:0] zs;
                zs = 2'(c % 4);
                drive(14 + c, (c * 11 + 2) % zof(zs), zs, 8 + c, rand_word());
            end else begin
                in_vld = 1'b0;
            end
            @(negedge clk);
        end
        chk(cnt == 6 && first == 3 && last == 8, "R9",
            $sformatf("writes act=%0d@%0d..%0d exp=6@3..8", cnt, first, last));
        for (int i = 0; i < 6; i++) check_col(14 + i, "R9");
    endtask

    task automatic t_stall();
        logic [VW-1:0] pr12;
        int bad;
        pr12 = rand_word();
        preload(10, rand_word()); preload(11, rand_word()); preload(12, pr12);
        // vector valid only while stalled: must be ignored
        @(negedge clk);
        stall = 1'b1;
        drive(12, 4, 2'd2, 0, rand_word());
        exp_w[12] = pr12; exp_f[12] = '0; exp_s[12] = '0;
        bad = 0;
        repeat (3) begin
            @(negedge clk);
            if (rd_en || wr_en) bad++;
        end
        in_vld = 1'b0; stall = 1'b0;
        chk(bad == 0, "R10", $sformatf("requests under stall act=%0d exp=0", bad));
        // two vectors, stalled twice in flight
        @(negedge clk);
        drive(10, 30, 2'd2, 20, rand_word());
        @(negedge clk);
        drive(11, 7, 2'd0, 5, rand_word());
        @(negedge clk);
        in_vld = 1'b0;
        stall = 1'b1;
        bad = 0;
        repeat (3) begin
            @(negedge clk);
            if (rd_en || wr_en) bad++;
        end
        stall = 1'b0;
        @(negedge clk);
        stall = 1'b1;
        repeat (2) begin
            @(negedge clk);
            if (rd_en || wr_en) bad++;
        end
        stall = 1'b0;
        chk(bad == 0, "R10", $sformatf("requests in flight stall act=%0d exp=0", bad));
        repeat (6) @(negedge clk);
        check_col(10, "R10");
        check_col(11, "R10");
        check_col(12, "R10");
    endtask

    task automatic t_det();
        det_addr = CW'(1);
        @(negedge clk);
        chk(det_flag === exp_f[1], "R11", $sformatf("col1 act=%h exp=%h", det_flag, exp_f[1]));
        det_addr = CW'(7);
        #1;
        chk(det_flag === exp_f[1], "R11", $sformatf("before edge act=%h exp=%h", det_flag, exp_f[1]));
        @(negedge clk);
        chk(det_flag === exp_f[7] && det_sign === exp_s[7], "R11",
            $sformatf("col7 act=%h exp=%h", det_flag, exp_f[7]));
    endtask

    initial begin
        t_reset();
        t_latency();
        t_shift();
        t_sat();
        t_thresh();
        t_b2b();
        t_stall();
        t_det();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule